// File: doc/BRIEF.md
# Burst-Aware Chip-Select Timing Generator

This block produces the active-low chip-select and output-enable strobes for one read access on an external parallel memory bus. Every control edge is given as a number of functional-clock cycles counted from the first cycle of the access. A new access begins when `start_i` is seen high while the block is idle. At that edge every timing field and mode input is captured, and the fields stay fixed until the access ends.

During a multi-beat page read, an internal access-phase counter runs until it reaches the read access time and then stops. It stays stopped while the remaining beats arrive, one every page access time. A capture strobe marks each beat. Because the counter is held, any edge programmed after the read access time moves later by the whole burst length, even though each field is only a few bits wide. If the chip-select or output-enable off time falls at or before the read access time, the strobe is held asserted until the last beat has been captured. A granularity input doubles every timing field.

Edges are numbered from the edge that accepts `start_i`. "Edge k" is the k-th rising clock edge after it. Times below are effective values: the field value, doubled when granularity applies (R7). Bursts assume the on times do not exceed the read access time. N is the number of beats, P the effective page time, and F = P·(N−1).

Top module: `cs_burst_timer`

## Requirements
- R1: While reset is held, `cs_n_o` and `oe_n_o` are 1, and `capture_o`, `done_o` and `busy_o` are 0.
- R2: For a single-beat access, `cs_n_o` goes low at edge cs_on+1 and returns high at edge cs_off+1. If cs_off ≤ cs_on, it never goes low.
- R3: `oe_n_o` follows the same rules as chip-select (R2, R5, R6), using the output-enable on and off fields.
- R4: N is 1 when `burst_en_i` is 0. Otherwise `page_code_i` selects it: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 16. `capture_o` pulses N times, first at edge rd+1 and then every P edges.
- R5: With N > 1 and an off time greater than rd, the strobe returns high at edge off+F+1, because the phase counter is frozen for F cycles.
- R6: With N > 1 and an off time ≤ rd (including zero and an off time equal to the on time), the strobe stays low until edge rd+F+2. That is the edge right after the last capture pulse.
- R7: When `gran_i` is 1 and the parameter GRAN_EN is 1, all six timing fields are doubled.
- R8: `done_o` is a one-cycle pulse at edge L+F+1, where L = max(cs_off, oe_off, rd+1)+1. Both strobes are high during that pulse.
- R9: `busy_o` is high from the accepting edge until the edge where `done_o` rises. A `start_i` seen while busy starts no further access.
- R10: A page access time field of zero is treated as one cycle.
- R11: Changes to the timing and mode inputs after the accepting edge do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Access request, accepted when idle |
| cs_on_i | input | TW | Chip-select assert time |
| cs_off_i | input | TW | Chip-select deassert time |
| oe_on_i | input | TW | Output-enable assert time |
| oe_off_i | input | TW | Output-enable deassert time |
| rd_time_i | input | TW | First-beat read access time |
| page_time_i | input | TW | Cycles between further beats |
| burst_en_i | input | 1 | Enables multi-beat reads |
| page_code_i | input | 2 | Beat-count select |
| gran_i | input | 1 | Doubles all timing fields |
| cs_n_o | output | 1 | Chip-select, active low, registered |
| oe_n_o | output | 1 | Output-enable, active low, registered |
| capture_o | output | 1 | Per-beat data capture strobe |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench builds the block with its default parameters: 5-bit fields, granularity doubling enabled and a 5-bit beat count. With these values a doubled 31-cycle field reaches the 62-cycle top of the range, and a 16-beat burst with a doubled page time freezes the counter for 450 cycles. That case pushes done well past any single field's limit and exercises the counter's extra width. Every page code is covered, as are the off-before-read-time hold cases and a zero page time.

// File: rtl/cs_timer_pkg.sv
package cs_timer_pkg;

   // index of each timing field in the captured configuration array
   localparam int unsigned IX_CS_ON   = 0;
   localparam int unsigned IX_CS_OFF  = 1;
   localparam int unsigned IX_OE_ON   = 2;
   localparam int unsigned IX_OE_OFF  = 3;
   localparam int unsigned IX_RD      = 4;
   localparam int unsigned IX_PAGE    = 5;
   localparam int unsigned NUM_FIELDS = 6;

   // number of data beats for one access
   function automatic logic [4:0] beat_count(input logic en, input logic [1:0] code);
      logic [4:0] n;
      if (!en) begin
         n = 5'd1;
      end else begin
         case (code)
            2'b00:   n = 5'd1;
            2'b01:   n = 5'd4;
            2'b10:   n = 5'd8;
            default: n = 5'd16;
         endcase
      end
      return n;
   endfunction

endpackage

// File: rtl/cs_time_scaler.sv
module cs_time_scaler #(
   parameter int unsigned TW      = 5,
   parameter int unsigned CW      = TW + 3,
   parameter bit          GRAN_EN = 1'b1
) (
   input  logic [TW-1:0] raw_i,
   input  logic          gran_i,
   output logic [CW-1:0] eff_o
);

   if (CW < TW + 1) begin : g_cw_bad
      $error("cs_time_scaler: CW must exceed TW");
   end

   if (GRAN_EN) begin : g_gran
      assign eff_o = gran_i ? CW'({raw_i, 1'b0}) : CW'(raw_i);
   end else begin : g_plain
      logic unused_gran;
      assign unused_gran = gran_i;
      assign eff_o       = CW'(raw_i);
   end

endmodule

// File: rtl/cs_phase_counter.sv
module cs_phase_counter #(
   parameter int unsigned CW     = 8,
   parameter int unsigned BEAT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CW-1:0]     rd_i,
   input  logic [CW-1:0]     page_i,
   input  logic [CW-1:0]     lim_i,
   input  logic [BEAT_W-1:0] beats_i,
   output logic              active_o,
   output logic [CW-1:0]     cnt_o,
   output logic [BEAT_W-1:0] rem_o,
   output logic              capture_o,
   output logic              done_o
);

   logic              active_q;
   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     pcnt_q;
   logic [BEAT_W-1:0] rem_q;
   logic              cap_q;
   logic              done_q;

   logic at_rd, cap_now, last_beat, frozen, at_end;

   always_comb begin
      at_rd     = active_q && (cnt_q == rd_i);
      cap_now   = at_rd && (pcnt_q == '0) && (rem_q != '0);
      last_beat = cap_now && (rem_q == BEAT_W'(1));
      frozen    = at_rd && (rem_q != '0) && !last_beat;
      at_end    = active_q && (cnt_q == lim_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         pcnt_q   <= '0;
         rem_q    <= '0;
         cap_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         cap_q  <= cap_now;
         if (!active_q) begin
            if (start_i) begin
               active_q <= 1'b1;
               cnt_q    <= '0;
               pcnt_q   <= '0;
               rem_q    <= beats_i;
            end
         end else if (at_end) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
         end else begin
            if (cap_now) begin
               rem_q <= rem_q - BEAT_W'(1);
            end
            if (frozen) begin
               pcnt_q <= (pcnt_q == page_i - CW'(1)) ? '0 : pcnt_q + CW'(1);
            end else begin
               cnt_q  <= cnt_q + CW'(1);
               pcnt_q <= '0;
            end
         end
      end
   end

   assign active_o  = active_q;
   assign cnt_o     = cnt_q;
   assign rem_o     = rem_q;
   assign capture_o = cap_q;
   assign done_o    = done_q;

   // R5
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> (cnt_q == $past(cnt_q)));

   // R4
   beats_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q)) |-> (rem_q <= $past(rem_q)));

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (cnt_q <= lim_i));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/cs_strobe_gen.sv
module cs_strobe_gen #(
   parameter int unsigned CW     = 8,
   parameter int unsigned BEAT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic [CW-1:0]     cnt_i,
   input  logic [BEAT_W-1:0] rem_i,
   input  logic              hold_en_i,
   input  logic [CW-1:0]     on_i,
   input  logic [CW-1:0]     off_i,
   output logic              strobe_n_o
);

   logic in_window, beats_pending, assert_now;
   logic strobe_n_q;

   always_comb begin
      in_window     = cnt_i < off_i;
      beats_pending = hold_en_i && (rem_i != '0);
      assert_now    = active_i && (cnt_i >= on_i) && (in_window || beats_pending);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_n_q <= 1'b1;
      end else begin
         strobe_n_q <= ~assert_now;
      end
   end

   assign strobe_n_o = strobe_n_q;

endmodule

// File: rtl/cs_burst_timer.sv
module cs_burst_timer
   import cs_timer_pkg::*;
#(
   parameter int unsigned TW      = 5,
   parameter int unsigned BEAT_W  = 5,
   parameter bit          GRAN_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [TW-1:0] cs_on_i,
   input  logic [TW-1:0] cs_off_i,
   input  logic [TW-1:0] oe_on_i,
   input  logic [TW-1:0] oe_off_i,
   input  logic [TW-1:0] rd_time_i,
   input  logic [TW-1:0] page_time_i,
   input  logic          burst_en_i,
   input  logic [1:0]    page_code_i,
   input  logic          gran_i,
   output logic          cs_n_o,
   output logic          oe_n_o,
   output logic          capture_o,
   output logic          busy_o,
   output logic          done_o
);

   localparam int unsigned CW = TW + 3;

   if (TW < 2 || TW > 12) begin : g_tw_bad
      $error("cs_burst_timer: TW out of range");
   end
   if (BEAT_W < 5) begin : g_beat_bad
      $error("cs_burst_timer: BEAT_W too narrow for 16 beats");
   end

   logic [TW-1:0]     raw_d [NUM_FIELDS];
   logic [TW-1:0]     raw_q [NUM_FIELDS];
   logic [CW-1:0]     eff   [NUM_FIELDS];
   logic [BEAT_W-1:0] beats_q;
   logic              gran_q;
   logic              busy;
   logic              accept;

   assign raw_d[IX_CS_ON]  = cs_on_i;
   assign raw_d[IX_CS_OFF] = cs_off_i;
   assign raw_d[IX_OE_ON]  = oe_on_i;
   assign raw_d[IX_OE_OFF] = oe_off_i;
   assign raw_d[IX_RD]     = rd_time_i;
   assign raw_d[IX_PAGE]   = page_time_i;

   assign accept = start_i && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FIELDS; i++) raw_q[i] <= '0;
         beats_q <= '0;
         gran_q  <= 1'b0;
      end else if (accept) begin
         for (int i = 0; i < NUM_FIELDS; i++) raw_q[i] <= raw_d[i];
         beats_q <= BEAT_W'(beat_count(burst_en_i, page_code_i));
         gran_q  <= gran_i;
      end
   end

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_scale
      cs_time_scaler #(.TW(TW), .CW(CW), .GRAN_EN(GRAN_EN)) u_scale (
         .raw_i  (raw_q[g]),
         .gran_i (gran_q),
         .eff_o  (eff[g])
      );
   end

   logic [CW-1:0] page_eff;
   logic [CW-1:0] span_max;
   logic [CW-1:0] lim;

   always_comb begin
      page_eff = (eff[IX_PAGE] == '0) ? CW'(1) : eff[IX_PAGE];
      span_max = eff[IX_RD] + CW'(1);
      if (eff[IX_CS_OFF] > span_max) span_max = eff[IX_CS_OFF];
      if (eff[IX_OE_OFF] > span_max) span_max = eff[IX_OE_OFF];
      lim = span_max + CW'(1);
   end

   logic [CW-1:0]     cnt;
   logic [BEAT_W-1:0] rem;
   logic              hold_en;

   assign hold_en = beats_q > BEAT_W'(1);

   cs_phase_counter #(.CW(CW), .BEAT_W(BEAT_W)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (accept),
      .rd_i      (eff[IX_RD]),
      .page_i    (page_eff),
      .lim_i     (lim),
      .beats_i   (BEAT_W'(beat_count(burst_en_i, page_code_i))),
      .active_o  (busy),
      .cnt_o     (cnt),
      .rem_o     (rem),
      .capture_o (capture_o),
      .done_o    (done_o)
   );

   cs_strobe_gen #(.CW(CW), .BEAT_W(BEAT_W)) u_cs_strobe (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (busy),
      .cnt_i      (cnt),
      .rem_i      (rem),
      .hold_en_i  (hold_en),
      .on_i       (eff[IX_CS_ON]),
      .off_i      (eff[IX_CS_OFF]),
      .strobe_n_o (cs_n_o)
   );

   cs_strobe_gen #(.CW(CW), .BEAT_W(BEAT_W)) u_oe_strobe (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (busy),
      .cnt_i      (cnt),
      .rem_i      (rem),
      .hold_en_i  (hold_en),
      .on_i       (eff[IX_OE_ON]),
      .off_i      (eff[IX_OE_OFF]),
      .strobe_n_o (oe_n_o)
   );

   assign busy_o = busy;

   // R8
   done_idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cs_n_o && oe_n_o));

   // R2
   cs_fall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> busy_o);

   // R4
   capture_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture_o |-> busy_o);

   // R9
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $fell(busy_o));

endmodule

// File: tb/cs_burst_timer_tb.sv
module cs_burst_timer_tb;

   localparam int CLK_NS  = 10;
   localparam int TW      = 5;
   localparam int WD_MAX  = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [TW-1:0] cs_on_i = '0, cs_off_i = '0, oe_on_i = '0, oe_off_i = '0;
   logic [TW-1:0] rd_time_i = '0, page_time_i = '0;
   logic          burst_en_i = 1'b0;
   logic [1:0]    page_code_i = 2'b00;
   logic          gran_i = 1'b0;
   logic          cs_n_o, oe_n_o, capture_o, busy_o, done_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #(CLK_NS/2) clk = ~clk;

   cs_burst_timer #(.TW(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cs_on_i(cs_on_i), .cs_off_i(cs_off_i), .oe_on_i(oe_on_i), .oe_off_i(oe_off_i),
      .rd_time_i(rd_time_i), .page_time_i(page_time_i),
      .burst_en_i(burst_en_i), .page_code_i(page_code_i), .gran_i(gran_i),
      .cs_n_o(cs_n_o), .oe_n_o(oe_n_o), .capture_o(capture_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_MAX) begin
         n_tests++;
         n_fail++;
         $display("FAIL [R9] watchdog: cycles %0d expected below %0d", cyc, WD_MAX);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL [%s] %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int beats_for(input int burst, input int code);
      if (burst == 0) return 1;
      case (code)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 16;
      endcase
   endfunction

   // edge where a strobe falls (0 = never), on <= rd assumed for bursts
   function automatic int exp_fall(input int on, input int off, input int nb);
      if (nb == 1 && off <= on) return 0;
      return on + 1;
   endfunction

   function automatic int exp_rise(input int on, input int off, input int rd, input int nb, input int f);
      if (nb == 1 && off <= on) return 0;
      if (off > rd) return off + f + 1;
      if (nb > 1) return rd + f + 2;
      return off + 1;
   endfunction

   task automatic run_access(input string tag,
                             input int on, input int off, input int oeon, input int oeoff,
                             input int rd, input int pg, input int burst, input int code,
                             input int gran, input int extra_n, input bit mutate);
      int s, on_s, off_s, oeon_s, oeoff_s, rd_s, p, nb, f, lim, done_exp;
      int cs_f, cs_r, oe_f, oe_r, cap_n, cap_first, cap_last, done_e, done_w, busy_done, refall;
      s       = (gran != 0) ? 2 : 1;
      on_s    = on * s;   off_s   = off * s;
      oeon_s  = oeon * s; oeoff_s = oeoff * s;
      rd_s    = rd * s;   p       = pg * s;
      if (p == 0) p = 1;
      nb  = beats_for(burst, code);
      f   = p * (nb - 1);
      lim = rd_s + 1;
      if (off_s > lim) lim = off_s;
      if (oeoff_s > lim) lim = oeoff_s;
      lim = lim + 1;
      done_exp = lim + f + 1;

      cs_f = 0; cs_r = 0; oe_f = 0; oe_r = 0; cap_n = 0; cap_first = 0; cap_last = 0;
      done_e = 0; done_w = 0; busy_done = -1; refall = 0;

      @(negedge clk);
      cs_on_i = TW'(on); cs_off_i = TW'(off); oe_on_i = TW'(oeon); oe_off_i = TW'(oeoff);
      rd_time_i = TW'(rd); page_time_i = TW'(pg);
      burst_en_i = (burst != 0); page_code_i = 2'(code); gran_i = (gran != 0);
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      check("R9", {tag, " busy after accept"}, int'(busy_o), 1);
      if (mutate) begin
         cs_on_i = '0; cs_off_i = 1; oe_on_i = '0; oe_off_i = 1;
         rd_time_i = '0; page_time_i = '0; burst_en_i = 1'b0; gran_i = 1'b0;
      end
      for (int n = 1; n <= 1500; n++) begin
         @(posedge clk);
         @(negedge clk);
         if (cs_n_o == 1'b0 && cs_f == 0) cs_f = n;
         if (cs_f != 0 && cs_r == 0 && cs_n_o == 1'b1) cs_r = n;
         if (oe_n_o == 1'b0 && oe_f == 0) oe_f = n;
         if (oe_f != 0 && oe_r == 0 && oe_n_o == 1'b1) oe_r = n;
         if (capture_o) begin
            cap_n++;
            if (cap_first == 0) cap_first = n;
            cap_last = n;
         end
         if (done_o) begin
            done_w++;
            if (done_e == 0) begin
               done_e    = n;
               busy_done = int'(busy_o);
            end
         end
         if (done_e != 0 && n > done_e && (cs_n_o == 1'b0 || busy_o)) refall = 1;
         start_i = (n == extra_n) ? 1'b1 : 1'b0;
         if (done_e != 0 && n >= done_e + 4) break;
      end
      start_i = 1'b0;

      check(tag,  {tag, " cs fall edge"},  cs_f, exp_fall(on_s, off_s, nb));
      check(tag,  {tag, " cs rise edge"},  cs_r, exp_rise(on_s, off_s, rd_s, nb, f));
      check("R3", {tag, " oe fall edge"},  oe_f, exp_fall(oeon_s, oeoff_s, nb));
      check("R3", {tag, " oe rise edge"},  oe_r, exp_rise(oeon_s, oeoff_s, rd_s, nb, f));
      check("R4", {tag, " capture count"}, cap_n, nb);
      check("R4", {tag, " first capture"}, cap_first, rd_s + 1);
      check("R4", {tag, " last capture"},  cap_last, rd_s + 1 + f);
      check("R8", {tag, " done edge"},     done_e, done_exp);
      check("R8", {tag, " done width"},    done_w, 1);
      check("R9", {tag, " busy at done"},  busy_done, 0);
      check("R9", {tag, " no extra access"}, refall, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      start_i = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "reset cs_n", int'(cs_n_o), 1);
      check("R1", "reset oe_n", int'(oe_n_o), 1);
      check("R1", "reset capture", int'(capture_o), 0);
      check("R1", "reset done", int'(done_o), 0);
      check("R1", "reset busy", int'(busy_o), 0);
      start_i = 1'b0;
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
   endtask

   task automatic t_single_beat();
      run_access("R2", 1, 6, 2, 5, 4, 2, 0, 0, 0, 0, 1'b0);
   endtask

   task automatic t_never_asserted();
      run_access("R2", 3, 3, 1, 2, 4, 1, 0, 0, 0, 0, 1'b0);
   endtask

   task automatic t_freeze_late_off();
      run_access("R5", 1, 8, 2, 9, 4, 3, 1, 1, 0, 0, 1'b0);
   endtask

   task automatic t_hold_zero_off();
      run_access("R6", 0, 0, 1, 2, 5, 2, 1, 3, 0, 0, 1'b0);
   endtask

   task automatic t_hold_equal_off();
      run_access("R6", 2, 2, 2, 2, 6, 1, 1, 2, 0, 0, 1'b0);
   endtask

   task automatic t_one_beat_code();
      run_access("R4", 1, 3, 1, 3, 5, 4, 1, 0, 0, 0, 1'b0);
   endtask

   task automatic t_burst_disabled();
      run_access("R4", 1, 3, 1, 3, 5, 4, 0, 3, 0, 0, 1'b0);
   endtask

   task automatic t_granularity();
      run_access("R7", 1, 7, 2, 6, 3, 2, 1, 1, 1, 0, 1'b0);
   endtask

   task automatic t_granularity_max();
      run_access("R7", 0, 31, 0, 31, 31, 15, 1, 3, 1, 0, 1'b0);
   endtask

   task automatic t_page_zero();
      run_access("R10", 1, 9, 1, 9, 3, 0, 1, 2, 0, 0, 1'b0);
   endtask

   task automatic t_start_while_busy();
      run_access("R9", 1, 8, 2, 9, 4, 3, 1, 1, 0, 6, 1'b0);
   endtask

   task automatic t_config_capture();
      run_access("R11", 1, 8, 2, 9, 4, 3, 1, 1, 0, 0, 1'b1);
   endtask

   initial begin
      t_reset();
      t_single_beat();
      t_never_asserted();
      t_freeze_late_off();
      t_hold_zero_off();
      t_hold_equal_off();
      t_one_beat_code();
      t_burst_disabled();
      t_granularity();
      t_granularity_max();
      t_page_zero();
      t_start_while_busy();
      t_config_capture();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule